// File: doc/BRIEF.md
# Serial Clock Freeze Control Register

This block sits between a bank of divided clock lanes and their output pins and decides, lane by lane, whether each clock runs or is parked at logic 0. A serial control word sets the choice. It arrives on a data pin that is sampled on the rising edge of a free-running serial clock. A word is framed by a single low start bit. Twelve control bits follow, one per serial clock period. The new word takes effect only after its last bit has arrived.

There are twelve controllable lanes, grouped as follows:

| Control bit | Lane | Output |
|---|---|---|
| 0 to 3 | 0 to 3 | First bank, in order |
| 4 to 7 | 4 to 7 | Second bank, in order |
| 8 to 10 | 8 to 10 | Outputs one to three of the third bank |
| 11 | 11 | Synchronisation pulse output |

Two further lanes carry the third bank's output zero and the loop feedback clock. No serial word can stop these two lanes, so a bad load cannot break the loop.

Each lane has a small gate cell. The cell brings the lane's control bit into the lane's own clock domain. It then changes the gate only while that lane clock is low, so every high phase that leaves the block has full width. While the active-low master reset is held, all fourteen outputs are low. When reset is released, every lane starts running.

Top module: `frz_out_ctrl`

## Requirements
- R1: While rst_n_i is low, every output (lane_clk_o and fixed_clk_o) is 0. After release, all twelve control bits are 1, so every lane runs.
- R2: A frame is a 0 start bit sampled on a rising sclk_i edge, followed by twelve data bits on the next twelve rising edges. The first data bit is D0. Data bit k controls lane_clk_o[k]: bits 0 to 3 drive the first bank, 4 to 7 the second bank, 8 to 10 the third bank's outputs 1 to 3, and 11 the sync lane.
- R3: A control bit of 1 makes lane_clk_o[k] follow lane_clk_i[k]. A 0 holds lane_clk_o[k] at 0.
- R4: The control bits in use change only on the rising sclk_i edge that samples D11. Bits received earlier in the frame have no effect on the outputs.
- R5: While idle, a 1 on sdi_i keeps the receiver idle, and the control bits are unchanged.
- R6: fixed_clk_o[1:0] follows fixed_clk_i[1:0] whenever reset is released, whatever the frames contain.
- R7: Each output rises only while its input is high, falls only with its input's falling edge, and every high pulse lasts exactly one full input high phase. No partial pulses occur when a lane is frozen or enabled.
- R8: Asserting reset in the middle of a frame discards the partial frame and restores all control bits to 1.
- R9: A start bit sampled on the rising edge right after D11 begins a new frame. Frames sent back to back are each decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| rst_n_i | input | 1 | Active-low master reset; when low, all outputs are held low |
| sdi_i | input | 1 | Serial control data; idles high |
| lane_clk_i | input | 12 | Clock inputs of the freezable lanes |
| lane_clk_o | output | 12 | Gated clock outputs of the freezable lanes |
| fixed_clk_i | input | 2 | Clock inputs of the two lanes that cannot be frozen |
| fixed_clk_o | output | 2 | Outputs of the lanes that cannot be frozen |

## Verification
The hardest case to reach from the ports is a decoder that applies bits before the frame ends. The outputs are the only way to see the control state, and they respond one or two lane clocks later. Frames are therefore sent that freeze the fastest lane while it is running. The bench counts that lane's output pulses in the second half of the frame, before D11 arrives, and those pulses must still be present. Truncated pulses are caught by a monitor that measures every output high pulse against its lane's half period. Mid-frame reset and back-to-back frames are driven directly, and the random frames come from a fixed seed.

// File: rtl/frz_pkg.sv
package frz_pkg;

    localparam int FRZ_BITS  = 12;
    localparam int FRZ_CNT_W = $clog2(FRZ_BITS);
    localparam logic [FRZ_CNT_W-1:0] FRZ_CNT_LAST = FRZ_CNT_W'(FRZ_BITS - 1);

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    typedef struct packed {
        rx_state_e             state;
        logic [FRZ_CNT_W-1:0]  cnt;
        logic [FRZ_BITS-1:0]   shreg;
        logic [FRZ_BITS-1:0]   ctrl;
    } rx_reg_t;

    localparam rx_reg_t RX_RESET = '{
        state: RX_IDLE,
        cnt:   '0,
        shreg: '1,
        ctrl:  '1
    };

endpackage

// File: rtl/frz_serial_rx.sv
module frz_serial_rx
    import frz_pkg::*;
(
    input  logic                sclk_i,
    input  logic                rst_n_i,
    input  logic                sdi_i,
    output logic [FRZ_BITS-1:0] ctrl_o
);

    rx_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            RX_IDLE: begin
                if (!sdi_i) begin
                    r_d.state = RX_SHIFT;
                    r_d.cnt   = '0;
                end
            end
            RX_SHIFT: begin
                r_d.shreg[r_q.cnt] = sdi_i;
                if (r_q.cnt == FRZ_CNT_LAST) begin
                    r_d.ctrl  = r_d.shreg;
                    r_d.state = RX_IDLE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d = RX_RESET;
        endcase
    end

    always_ff @(posedge sclk_i or negedge rst_n_i) begin
        if (!rst_n_i) r_q <= RX_RESET;
        else          r_q <= r_d;
    end

    assign ctrl_o = r_q.ctrl;

    AST_CNT_BOUND: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
        (r_q.state == RX_SHIFT) |-> (r_q.cnt <= FRZ_CNT_LAST)); // R2

    AST_START_ENTER: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
        (r_q.state == RX_IDLE && !sdi_i) |=> (r_q.state == RX_SHIFT && r_q.cnt == '0)); // R2

    AST_LOAD_AT_END: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
        (r_q.ctrl != $past(r_q.ctrl)) |->
        $past(r_q.state == RX_SHIFT && r_q.cnt == FRZ_CNT_LAST)); // R4

    AST_IDLE_HOLD: assert property (@(posedge sclk_i) disable iff (!rst_n_i)
        (r_q.state == RX_IDLE && sdi_i) |=> (r_q.state == RX_IDLE && $stable(r_q.ctrl))); // R5

endmodule

// File: rtl/frz_clk_gate.sv
module frz_clk_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    output logic clk_o
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_d, sync_q;
    logic         en_d, en_q;

    always_comb begin
        if (SYNC_STAGES > 1) sync_d = {sync_q[TOP-1:0], en_i};
        else                 sync_d = en_i;
        en_d = sync_q[TOP];
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= sync_d;
    end

    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) en_q <= 1'b0;
        else          en_q <= en_d;
    end

    assign clk_o = clk_i & en_q;

    AST_EN_VIA_SYNC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(en_q) |-> sync_q[TOP]); // R7

endmodule

// File: rtl/frz_out_ctrl.sv
module frz_out_ctrl
    import frz_pkg::*;
#(
    parameter int NUM_FIXED   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 sclk_i,
    input  logic                 rst_n_i,
    input  logic                 sdi_i,
    input  logic [FRZ_BITS-1:0]  lane_clk_i,
    output logic [FRZ_BITS-1:0]  lane_clk_o,
    input  logic [NUM_FIXED-1:0] fixed_clk_i,
    output logic [NUM_FIXED-1:0] fixed_clk_o
);

    logic [FRZ_BITS-1:0] ctrl;

    frz_serial_rx u_rx (
        .sclk_i  (sclk_i),
        .rst_n_i (rst_n_i),
        .sdi_i   (sdi_i),
        .ctrl_o  (ctrl)
    );

    for (genvar i = 0; i < FRZ_BITS; i++) begin : g_lane
        frz_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_i   (lane_clk_i[i]),
            .rst_n_i (rst_n_i),
            .en_i    (ctrl[i]),
            .clk_o   (lane_clk_o[i])
        );
    end

    for (genvar j = 0; j < NUM_FIXED; j++) begin : g_fixed
        frz_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_i   (fixed_clk_i[j]),
            .rst_n_i (rst_n_i),
            .en_i    (1'b1),
            .clk_o   (fixed_clk_o[j])
        );
    end

endmodule

// File: tb/tb_frz_out_ctrl.sv
`timescale 1ns/1ps
module tb_frz_out_ctrl;

    localparam int NL = 12;
    localparam int NF = 2;
    localparam int NA = NL + NF;

    logic          sclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sdi = 1'b1;
    logic [NL-1:0] lane_i;
    logic [NL-1:0] lane_o;
    logic [NF-1:0] fix_i;
    logic [NF-1:0] fix_o;
    logic [NA-1:0] all_i, all_o;

    int nchk = 0;
    int nerr = 0;
    int runt_err = 0;
    bit done = 0;
    int rises [NA];
    time t_up [NA];
    logic [NL-1:0] exp_ctrl;

    assign all_i = {fix_i, lane_i};
    assign all_o = {fix_o, lane_o};

    frz_out_ctrl dut (
        .sclk_i      (sclk),
        .rst_n_i     (rst_n),
        .sdi_i       (sdi),
        .lane_clk_i  (lane_i),
        .lane_clk_o  (lane_o),
        .fixed_clk_i (fix_i),
        .fixed_clk_o (fix_o)
    );

    always #10 sclk = ~sclk;

    function automatic int half_of(int g);
        return 4 + g;
    endfunction

    for (genvar g = 0; g < NL; g++) begin : g_lck
        initial begin
            lane_i[g] = 1'b0;
            forever #(half_of(g)) lane_i[g] = ~lane_i[g];
        end
    end
    for (genvar g = 0; g < NF; g++) begin : g_fck
        initial begin
            fix_i[g] = 1'b0;
            forever #(half_of(NL + g)) fix_i[g] = ~fix_i[g];
        end
    end

    // R7 monitor: each output high pulse must sit inside a full input high phase
    for (genvar g = 0; g < NA; g++) begin : g_mon
        initial rises[g] = 0;
        always @(posedge all_o[g]) begin
            rises[g]++;
            t_up[g] = $time;
            if (all_i[g] !== 1'b1) runt_err++;
        end
        always @(negedge all_o[g]) begin
            if (rst_n) begin
                if (all_i[g] !== 1'b0) runt_err++;
                if (($time - t_up[g]) != time'(half_of(g))) runt_err++;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic check_lanes(string req, bit in_reset);
        int snap [NA];
        int d;
        #200;
        for (int g = 0; g < NA; g++) snap[g] = rises[g];
        #600;
        for (int g = 0; g < NA; g++) begin
            d = rises[g] - snap[g];
            if (in_reset || (g < NL && !exp_ctrl[g])) begin
                chk(d == 0 && all_o[g] == 1'b0, req, $sformatf("lane %0d frozen rises", g), d, 0);
            end else begin
                chk(d >= 10, (g >= NL) ? "R6" : req, $sformatf("lane %0d running rises", g), d, 10);
            end
        end
    endtask

    // mid_chk: watch lane 0 during the frame (R4) when the frame freezes it
    task automatic send_frame(logic [NL-1:0] bits, bit idle_after, bit mid_chk);
        int s0;
        @(negedge sclk) sdi = 1'b0;
        for (int k = 0; k < NL; k++) begin
            @(negedge sclk) sdi = bits[k];
            if (k == 6) s0 = rises[0];
            if (k == 10 && mid_chk)
                chk(rises[0] - s0 >= 5, "R4", "lane 0 runs before D11", rises[0] - s0, 5);
        end
        if (idle_after) @(negedge sclk) sdi = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #2ms;
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [NL-1:0] v;
        void'($urandom(32'd4242));
        exp_ctrl = '1;
        // R1: reset holds every output low
        check_lanes("R1", 1'b1);
        @(negedge sclk) rst_n = 1'b1;
        // R1: after release all lanes run
        check_lanes("R1", 1'b0);
        // R5: long idle with sdi high changes nothing
        repeat (40) @(negedge sclk);
        check_lanes("R5", 1'b0);
        // R2 R3 R4: freeze all; lane 0 must keep running until D11
        send_frame('0, 1'b1, 1'b1);
        exp_ctrl = '0;
        check_lanes("R3", 1'b0);
        // R2: bit-to-lane mapping with an asymmetric pattern
        send_frame(12'h5A3, 1'b1, 1'b0);
        exp_ctrl = 12'h5A3;
        check_lanes("R2", 1'b0);
        send_frame(12'hF00 | 12'h00E, 1'b1, 1'b0);
        exp_ctrl = 12'hF0E;
        check_lanes("R2", 1'b0);
        // R9: back-to-back frames
        send_frame(12'h001, 1'b0, 1'b0);
        send_frame(12'hC3C, 1'b1, 1'b0);
        exp_ctrl = 12'hC3C;
        check_lanes("R9", 1'b0);
        // R8: reset in the middle of a frame
        @(negedge sclk) sdi = 1'b0;
        for (int k = 0; k < 6; k++) @(negedge sclk) sdi = 1'b0;
        rst_n = 1'b0;
        sdi = 1'b1;
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        exp_ctrl = '1;
        check_lanes("R8", 1'b0);
        // R3: random frames
        for (int n = 0; n < 6; n++) begin
            v = NL'($urandom());
            send_frame(v, 1'b1, exp_ctrl[0] && !v[0]);
            exp_ctrl = v;
            check_lanes("R3", 1'b0);
        end
        // R3: re-enable everything
        send_frame('1, 1'b1, 1'b0);
        exp_ctrl = '1;
        check_lanes("R3", 1'b0);
        chk(runt_err == 0, "R7", "partial or misplaced pulses", runt_err, 0);
        finish_run();
    end

endmodule